// File: doc/BRIEF.md
# Transmit Timestamp Snapshot Capture

This block records the departure time of precision time protocol event messages, one capture unit per port channel. Each channel watches a transmit pulse that comes with a 4-bit message-type code and a master/slave mode bit. When the pulse marks the message that the current mode cares about, the channel stores the free-running 64-bit system time from that same clock cycle. It then raises a sticky event flag.

Software reads the stored time as two 32-bit words through a simple register port with combinational read data. It then clears the flag by writing a one to it. While the flag is up, the stored time cannot move, so both halves of a read belong to one capture. A qualifying transmission that arrives while the flag is still set is dropped, and an overrun bit records the loss. A per-channel enable gates the flag onto an interrupt line.

Top module: `tx_stamp_capture`

## Requirements
- R1: With the mode bit high (master), a transmit pulse triggers a capture only when the message-type code is 0 (Sync). Any other code leaves the channel unchanged.
- R2: With the mode bit low (slave), a transmit pulse triggers a capture only when the message-type code is 1 (Delay_Req). Any other code, Sync included, leaves the channel unchanged.
- R3: The low snapshot word holds time bits 31:0 and the high word holds bits 63:32. Both words reset to zero, and writes to them have no effect.
- R4: The status register has the event flag at bit 0. A capture sets the flag, and it stays set until a write with bit 0 equal to 1. Writing 0 to bit 0 leaves it set. The flag resets to 0.
- R5: While the event flag is set, a qualifying transmission does not change either snapshot word. After the flag is cleared, the next qualifying transmission captures again.
- R6: A qualifying transmission that arrives while the flag is set and no clear is written sets the overrun bit, status bit 1. The overrun bit is cleared by writing 1 to bit 1, and clearing it does not touch bit 0.
- R7: If a qualifying transmission and a write of 1 to status bit 0 fall in the same cycle, the capture wins. The flag stays set and the snapshot takes the new time.
- R8: The captured value equals the system time input in the clock cycle in which the transmit pulse is high.
- R9: Interrupt bit n equals the event flag of channel n ANDed with bit 0 of that channel's read/write control register. The control register resets to 0.
- R10: Channel n's registers start at 0x40 + n*0x20. Within a channel, the control register is at offset 0x0, status at 0x4, the low word at 0x8 and the high word at 0xC. Any other address reads 0. Channels do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released synchronously inside the block |
| sys_time | input | 64 | Free-running system time |
| tx_pulse | input | NUM_CH | One-cycle pulse per channel: a timing message left the port |
| tx_msg_type | input | 4*NUM_CH | Message-type code per channel (4 bits each, channel n at bits 4n+3:4n) |
| tx_master | input | NUM_CH | Mode per channel: 1 master, 0 slave |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Write strobe for the current address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq | output | NUM_CH | Per-channel interrupt |

## Verification
Transmit pulses are sent with every mix of mode bit and message code: master with Sync, master with Delay_Req, master with an unused code, slave with Delay_Req and slave with Sync. This separates a correct mode-dependent trigger from a trigger that ignores the mode or decodes the wrong code. Each capture uses a time value with different high and low halves, which exposes swapped or stale words. A second capture with the flag still set, a capture on the same cycle as a clear, and separate clears of bit 0 and bit 1 tell apart the freeze, overrun and priority rules. A capture on one channel, followed by reads of the other channels and of unmapped addresses, checks the address map and that channels stay independent.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned TIME_W = 64;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CODE_W = 4;

  typedef logic [CODE_W-1:0] msg_code_t;

  localparam msg_code_t CODE_SYNC      = 4'h0;
  localparam msg_code_t CODE_DELAY_REQ = 4'h1;

  localparam int unsigned OFS_CTRL   = 'h0;
  localparam int unsigned OFS_STATUS = 'h4;
  localparam int unsigned OFS_SNAPLO = 'h8;
  localparam int unsigned OFS_SNAPHI = 'hC;
endpackage

// File: rtl/tsc_rst_sync.sv
module tsc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/tsc_qualify.sv
module tsc_qualify
  import tsc_pkg::*;
(
  input  logic      pulse,
  input  msg_code_t msg_type,
  input  logic      is_master,
  output logic      hit
);
  logic code_match;

  always_comb begin
    if (is_master) code_match = (msg_type == CODE_SYNC);
    else           code_match = (msg_type == CODE_DELAY_REQ);
    hit = pulse & code_match;
  end
endmodule

// File: rtl/tsc_channel.sv
module tsc_channel
  import tsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [TIME_W-1:0] sys_time,
  input  logic              ctrl_we,
  input  logic              en_bit,
  input  logic              status_we,
  input  logic              w_evt,
  input  logic              w_ovr,
  output logic [TIME_W-1:0] snap,
  output logic              evt,
  output logic              ovr,
  output logic              irq_en,
  output logic              irq
);
  logic clr_evt, clr_ovr, take, drop;
  logic evt_d, ovr_d, en_d;

  always_comb begin
    clr_evt = status_we & w_evt;
    clr_ovr = status_we & w_ovr;
    take    = hit & (~evt | clr_evt);
    drop    = hit & evt & ~clr_evt;
    evt_d   = take | (evt & ~clr_evt);
    ovr_d   = drop | (ovr & ~clr_ovr);
    en_d    = ctrl_we ? en_bit : irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt    <= 1'b0;
      ovr    <= 1'b0;
      irq_en <= 1'b0;
    end else begin
      evt    <= evt_d;
      ovr    <= ovr_d;
      irq_en <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap <= '0;
    end else if (take) begin
      snap <= sys_time;
    end
  end

  assign irq = evt & irq_en;
endmodule

// File: rtl/tsc_regs.sv
module tsc_regs
  import tsc_pkg::*;
#(
  parameter int unsigned NUM_CH    = 3,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CH_BASE   = 'h40,
  parameter int unsigned CH_STRIDE = 'h20
) (
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic                           reg_wr,
  input  logic [NUM_CH-1:0][TIME_W-1:0]  snap,
  input  logic [NUM_CH-1:0]              evt,
  input  logic [NUM_CH-1:0]              ovr,
  input  logic [NUM_CH-1:0]              irq_en,
  output logic [NUM_CH-1:0]              ctrl_we,
  output logic [NUM_CH-1:0]              status_we,
  output logic [WORD_W-1:0]              reg_rdata
);
  logic [ADDR_W-1:0] ch_base;

  always_comb begin
    ctrl_we   = '0;
    status_we = '0;
    reg_rdata = '0;
    ch_base   = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      ch_base = ADDR_W'(CH_BASE + c * CH_STRIDE);
      if (reg_addr == ch_base + ADDR_W'(OFS_CTRL)) begin
        reg_rdata  = {{(WORD_W-1){1'b0}}, irq_en[c]};
        ctrl_we[c] = reg_wr;
      end
      if (reg_addr == ch_base + ADDR_W'(OFS_STATUS)) begin
        reg_rdata    = {{(WORD_W-2){1'b0}}, ovr[c], evt[c]};
        status_we[c] = reg_wr;
      end
      if (reg_addr == ch_base + ADDR_W'(OFS_SNAPLO))
        reg_rdata = snap[c][WORD_W-1:0];
      if (reg_addr == ch_base + ADDR_W'(OFS_SNAPHI))
        reg_rdata = snap[c][TIME_W-1:WORD_W];
    end
  end
endmodule

// File: rtl/tx_stamp_capture.sv
module tx_stamp_capture
  import tsc_pkg::*;
#(
  parameter int unsigned NUM_CH    = 3,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CH_BASE   = 'h40,
  parameter int unsigned CH_STRIDE = 'h20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [63:0]                sys_time,
  input  logic [NUM_CH-1:0]          tx_pulse,
  input  logic [NUM_CH*4-1:0]        tx_msg_type,
  input  logic [NUM_CH-1:0]          tx_master,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic                       reg_wr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  output logic [NUM_CH-1:0]          irq
);
  logic                          rst_int_n;
  logic [NUM_CH-1:0]             hit;
  logic [NUM_CH-1:0][TIME_W-1:0] snap;
  logic [NUM_CH-1:0]             evt, ovr, irq_en;
  logic [NUM_CH-1:0]             ctrl_we, status_we;
  logic                          unused_wdata;

  assign unused_wdata = ^reg_wdata[31:2];

  tsc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    tsc_qualify u_qualify (
      .pulse     (tx_pulse[i]),
      .msg_type  (tx_msg_type[i*CODE_W +: CODE_W]),
      .is_master (tx_master[i]),
      .hit       (hit[i])
    );

    tsc_channel u_channel (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .hit       (hit[i]),
      .sys_time  (sys_time),
      .ctrl_we   (ctrl_we[i]),
      .en_bit    (reg_wdata[0]),
      .status_we (status_we[i]),
      .w_evt     (reg_wdata[0]),
      .w_ovr     (reg_wdata[1]),
      .snap      (snap[i]),
      .evt       (evt[i]),
      .ovr       (ovr[i]),
      .irq_en    (irq_en[i]),
      .irq       (irq[i])
    );
  end

  tsc_regs #(
    .NUM_CH    (NUM_CH),
    .ADDR_W    (ADDR_W),
    .CH_BASE   (CH_BASE),
    .CH_STRIDE (CH_STRIDE)
  ) u_regs (
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .snap      (snap),
    .evt       (evt),
    .ovr       (ovr),
    .irq_en    (irq_en),
    .ctrl_we   (ctrl_we),
    .status_we (status_we),
    .reg_rdata (reg_rdata)
  );
endmodule

// File: rtl/tsc_channel_chk.sv
module tsc_channel_chk
  import tsc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              hit,
  input logic [TIME_W-1:0] sys_time,
  input logic              status_we,
  input logic              w_evt,
  input logic [TIME_W-1:0] snap,
  input logic              evt,
  input logic              ovr,
  input logic              irq_en,
  input logic              irq
);
  AST_CAPTURE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !evt |=> evt && snap == $past(sys_time)); // R8

  AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    evt && !(status_we && w_evt) |=> evt && $stable(snap)); // R5

  AST_DROP_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    hit && evt && !(status_we && w_evt) |=> ovr); // R6

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    status_we && w_evt && !hit |=> !evt); // R4

  AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit && evt && status_we && w_evt |=> evt && snap == $past(sys_time)); // R7

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !hit && !evt |=> !evt && $stable(snap)); // R1

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> evt && irq_en); // R9
endmodule

bind tsc_channel tsc_channel_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hit       (hit),
  .sys_time  (sys_time),
  .status_we (status_we),
  .w_evt     (w_evt),
  .snap      (snap),
  .evt       (evt),
  .ovr       (ovr),
  .irq_en    (irq_en),
  .irq       (irq)
);

// File: tb/tx_stamp_capture_bench.sv
module tx_stamp_capture_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;

  logic            clk;
  logic            rst_n;
  logic [63:0]     sys_time;
  logic [NCH-1:0]  tx_pulse;
  logic [NCH*4-1:0] tx_msg_type;
  logic [NCH-1:0]  tx_master;
  logic [7:0]      reg_addr;
  logic            reg_wr;
  logic [31:0]     reg_wdata;
  logic [31:0]     reg_rdata;
  logic [NCH-1:0]  irq;

  int n_cmp;
  int n_bad;
  int pending;
  bit done;

  logic [7:0]  addr_q[$];
  logic [31:0] exp_q[$];
  bit          kind_q[$];
  string       tag_q[$];

  tx_stamp_capture u_tx_stamp_capture (
    .clk(clk), .rst_n(rst_n), .sys_time(sys_time), .tx_pulse(tx_pulse),
    .tx_msg_type(tx_msg_type), .tx_master(tx_master), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] ra(int ch, int ofs);
    return 8'(8'h40 + ch * 8'h20 + ofs);
  endfunction

  // monitor: pops expected items and compares against the design
  initial begin
    forever begin
      @(negedge clk);
      if (addr_q.size() > 0) begin
        logic [7:0]  a;
        logic [31:0] e;
        logic [31:0] got;
        bit          k;
        string       t;
        a = addr_q.pop_front();
        e = exp_q.pop_front();
        k = kind_q.pop_front();
        t = tag_q.pop_front();
        if (!k) reg_addr = a;
        #1;
        got = k ? 32'(irq) : reg_rdata;
        n_cmp++;
        if (got !== e) begin
          n_bad++;
          $display("FAIL %s addr=%h actual=%h expected=%h", t, a, got, e);
        end
        pending--;
      end
    end
  end

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string t);
    addr_q.push_back(a); exp_q.push_back(e); kind_q.push_back(1'b0); tag_q.push_back(t);
    pending++;
    wait (pending == 0);
  endtask

  task automatic expect_irq(input logic [31:0] e, input string t);
    addr_q.push_back(8'h00); exp_q.push_back(e); kind_q.push_back(1'b1); tag_q.push_back(t);
    pending++;
    wait (pending == 0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic send(input int ch, input logic [3:0] code, input bit master,
                      input logic [63:0] t, input bit clr);
    @(negedge clk);
    sys_time = t;
    tx_msg_type[ch*4 +: 4] = code;
    tx_master[ch] = master;
    tx_pulse[ch] = 1'b1;
    if (clr) begin
      reg_addr = ra(ch, 4); reg_wdata = 32'h1; reg_wr = 1'b1;
    end
    @(negedge clk);
    tx_pulse = '0;
    reg_wr = 1'b0;
    sys_time = ~t;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; pending = 0; done = 0;
    rst_n = 1'b0; sys_time = '0; tx_pulse = '0; tx_msg_type = '0; tx_master = '0;
    reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    expect_rd(ra(0, 8),  32'h0, "R3 reset low word");
    expect_rd(ra(0, 12), 32'h0, "R3 reset high word");
    expect_rd(ra(0, 4),  32'h0, "R4 reset status");
    expect_rd(ra(0, 0),  32'h0, "R9 reset control");
    expect_irq(32'h0, "R9 reset irq");

    // wrong mode/code combinations
    send(0, 4'h1, 1'b1, 64'h1111_2222_3333_4444, 1'b0);
    expect_rd(ra(0, 4), 32'h0, "R1 master Delay_Req ignored");
    send(0, 4'h5, 1'b1, 64'h1111_2222_3333_4444, 1'b0);
    expect_rd(ra(0, 4), 32'h0, "R1 master other code ignored");
    send(0, 4'h0, 1'b0, 64'h1111_2222_3333_4444, 1'b0);
    expect_rd(ra(0, 4), 32'h0, "R2 slave Sync ignored");
    expect_rd(ra(0, 8), 32'h0, "R2 slave Sync snapshot untouched");

    // master Sync capture
    send(0, 4'h0, 1'b1, 64'h1234_5678_9ABC_DEF0, 1'b0);
    expect_rd(ra(0, 4),  32'h1, "R1 master Sync sets flag");
    expect_rd(ra(0, 8),  32'h9ABC_DEF0, "R8 low word same-cycle time");
    expect_rd(ra(0, 12), 32'h1234_5678, "R3 high word");

    // read-only snapshot words
    wr(ra(0, 8), 32'hFFFF_FFFF);
    wr(ra(0, 12), 32'hFFFF_FFFF);
    expect_rd(ra(0, 8),  32'h9ABC_DEF0, "R3 low word write ignored");
    expect_rd(ra(0, 12), 32'h1234_5678, "R3 high word write ignored");

    // write 0 does not clear
    wr(ra(0, 4), 32'h0);
    expect_rd(ra(0, 4), 32'h1, "R4 write zero keeps flag");

    // second capture while set is dropped
    send(0, 4'h0, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0);
    expect_rd(ra(0, 8),  32'h9ABC_DEF0, "R5 low word frozen");
    expect_rd(ra(0, 12), 32'h1234_5678, "R5 high word frozen");
    expect_rd(ra(0, 4),  32'h3, "R6 overrun set");

    // interrupt gating
    expect_irq(32'h0, "R9 irq masked");
    wr(ra(0, 0), 32'h1);
    expect_rd(ra(0, 0), 32'h1, "R9 control readback");
    expect_irq(32'h1, "R9 irq enabled");

    // clear overrun only
    wr(ra(0, 4), 32'h2);
    expect_rd(ra(0, 4), 32'h1, "R6 overrun cleared flag kept");

    // capture and clear in the same cycle
    send(0, 4'h0, 1'b1, 64'h0F0E_0D0C_0B0A_0908, 1'b1);
    expect_rd(ra(0, 4),  32'h1, "R7 flag kept on same-cycle clear");
    expect_rd(ra(0, 8),  32'h0B0A_0908, "R7 low word updated");
    expect_rd(ra(0, 12), 32'h0F0E_0D0C, "R7 high word updated");

    // clear and re-arm
    wr(ra(0, 4), 32'h1);
    expect_rd(ra(0, 4), 32'h0, "R4 write one clears flag");
    expect_irq(32'h0, "R9 irq drops with flag");
    send(0, 4'h0, 1'b1, 64'h7654_3210_FEDC_BA98, 1'b0);
    expect_rd(ra(0, 8), 32'hFEDC_BA98, "R5 capture after clear");

    // slave Delay_Req on channel 1
    send(1, 4'h1, 1'b0, 64'h0000_00C1_5555_6666, 1'b0);
    expect_rd(ra(1, 4),  32'h1, "R2 slave Delay_Req sets flag");
    expect_rd(ra(1, 8),  32'h5555_6666, "R2 slave low word");
    expect_rd(ra(1, 12), 32'h0000_00C1, "R10 channel 1 high word");
    expect_rd(ra(2, 4),  32'h0, "R10 channel 2 untouched");
    expect_rd(ra(0, 12), 32'h7654_3210, "R10 channel 0 untouched");
    expect_irq(32'h1, "R10 channel 1 irq not enabled");
    expect_rd(8'h00, 32'h0, "R10 unmapped address");
    expect_rd(8'h50, 32'h0, "R10 unmapped gap address");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule